// File: doc/BRIEF.md
# Self-Synchronizing Scrambler with Four-Level Symbol Codec

This block sits between a line framer and the analog front end of a two-bits-per-symbol baseband modem. On the transmit side it takes one line bit per cycle. It scrambles the bit with a self-synchronizing 23-stage shift register, pairs consecutive line bits and emits one signed four-level symbol for every two bits. The symbol rate is therefore half the bit rate. Sync-word and stuff bits are marked by the framer. They travel through untouched and leave the scrambler history as it was.

The receive side takes hard-decided symbols, one per strobe, together with a per-bit bypass mask. It turns each symbol back into a bit pair and runs both bits through the matching descrambler. Because the descrambler history is built from received line bits, it locks onto any far-end transmitter after 23 non-bypassed bits with no training. A direction input chooses between the downstream and upstream tap sets. Both tap sets default to stages 5 and 23.

Top module: `quat_line_codec`

## Requirements
- R1: After a synchronous reset, `tx_sym_valid` and `rx_dibit_valid` are 0 and `tx_sym` reads 0. Both shift registers are cleared to all zeros.
- R2: A transmitted non-bypassed line bit equals the input bit XOR the line bits sent 5 and 23 non-bypassed bits earlier, where bits before reset count as 0. That line bit then enters the history.
- R3: A transmit bit with `tx_bypass`=1 is sent on the line unchanged and does not alter the scrambler history.
- R4: The first valid bit after reset opens a pair, and every second valid bit (bypassed or not) closes it. `tx_sym_valid` pulses for one cycle, in the cycle after the closing bit is accepted.
- R5: Within a pair, the first line bit gives the sign and the second gives the magnitude. The mapping is 10→+3, 11→+1, 01→−1, 00→−3, with `tx_sym` in 3-bit two's complement.
- R6: A received symbol is demapped by the inverse of R5 into a first bit (`rx_dibit[1]`) and a second bit (`rx_dibit[0]`). The result appears with `rx_dibit_valid` one cycle after `rx_sym_valid`.
- R7: A non-bypassed received bit is output as the received bit XOR the received bits 5 and 23 non-bypassed bits earlier. The received bit then enters the history, and the first bit is handled before the second.
- R8: A received bit whose flag in `rx_bypass` is set is output unchanged and leaves the descrambler history unaltered. `rx_bypass[1]` flags the first bit and `rx_bypass[0]` flags the second.
- R9: After 23 non-bypassed received bits, the descrambled output equals the far-end data, whatever the far-end scrambler state was.
- R10: Cycles without a valid strobe change neither history nor pairing, and they raise no output strobe. `dir_up` chooses the tap set for each bit as it is processed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dir_up | input | 1 | 1 selects the upstream tap set, 0 the downstream set |
| tx_bit_valid | input | 1 | Transmit bit strobe |
| tx_bit | input | 1 | Transmit data bit |
| tx_bypass | input | 1 | Bit is sync or stuff: send it unscrambled |
| tx_sym_valid | output | 1 | One-cycle strobe for a new symbol |
| tx_sym | output | 3 | Signed symbol, ±1 or ±3 |
| rx_sym_valid | input | 1 | Receive symbol strobe |
| rx_sym | input | 3 | Hard-decided signed symbol |
| rx_bypass | input | 2 | Per-bit unscrambled flags, [1] for the first bit |
| rx_dibit_valid | output | 1 | Strobe for a recovered bit pair |
| rx_dibit | output | 2 | Descrambled pair, [1] first |

## Verification
The bench interleaves bypassed bits with scrambled ones and idle gaps. A design that shifted bypassed or idle bits into its history, or that restarted pairing after a bypassed bit, would then put wrong symbols on the line. Directed bypassed pairs cover each level of the map, so a swapped sign and magnitude role, or an inverted magnitude, shows up as the wrong level. On receive, the bench starts a far-end scrambler from a random state and checks that data recovers exactly once 23 bits have passed. It also checks that the first bit of a symbol is descrambled before the second, which a design that used stale history for the second bit would get wrong.

// File: rtl/qlc_pkg.sv
package qlc_pkg;

    // Signed four-level line symbol.
    typedef logic signed [2:0] sym_t;

    // A bit pair: sign bit travels first, magnitude bit second.
    typedef struct packed {
        logic sgn;
        logic mag;
    } dibit_t;

    localparam sym_t LVL_P3 = 3'sd3;
    localparam sym_t LVL_P1 = 3'sd1;
    localparam sym_t LVL_M1 = -3'sd1;
    localparam sym_t LVL_M3 = -3'sd3;

    function automatic sym_t dibit_to_sym(input dibit_t d);
        sym_t s;
        case ({d.sgn, d.mag})
            2'b10:   s = LVL_P3;
            2'b11:   s = LVL_P1;
            2'b01:   s = LVL_M1;
            default: s = LVL_M3;
        endcase
        return s;
    endfunction

    function automatic dibit_t sym_to_dibit(input sym_t s);
        dibit_t d;
        d.sgn = ~s[2];
        d.mag = (s == LVL_P1) || (s == LVL_M1);
        return d;
    endfunction

endpackage

// File: rtl/qlc_tx.sv
module qlc_tx
    import qlc_pkg::*;
#(
    parameter int DN_A = 5,
    parameter int DN_B = 23,
    parameter int UP_A = 5,
    parameter int UP_B = 23
) (
    input  logic clk,
    input  logic rst,
    input  logic dir_up,
    input  logic bit_valid,
    input  logic bit_in,
    input  logic bypass,
    output logic sym_valid,
    output sym_t sym
);
    localparam int MAX_DN = (DN_A > DN_B) ? DN_A : DN_B;
    localparam int MAX_UP = (UP_A > UP_B) ? UP_A : UP_B;
    localparam int SR_W   = (MAX_DN > MAX_UP) ? MAX_DN : MAX_UP;

    logic [SR_W-1:0] hist_q;
    logic            half_q;
    logic            first_q;
    logic            fb;
    logic            line_bit;

    always_comb begin
        fb       = dir_up ? (hist_q[UP_A-1] ^ hist_q[UP_B-1])
                          : (hist_q[DN_A-1] ^ hist_q[DN_B-1]);
        line_bit = bypass ? bit_in : (bit_in ^ fb);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q    <= '0;
            half_q    <= 1'b0;
            first_q   <= 1'b0;
            sym_valid <= 1'b0;
            sym       <= '0;
        end else begin
            sym_valid <= 1'b0;
            if (bit_valid) begin
                if (!bypass)
                    hist_q <= {hist_q[SR_W-2:0], line_bit};
                if (!half_q) begin
                    first_q <= line_bit;
                    half_q  <= 1'b1;
                end else begin
                    sym       <= dibit_to_sym('{sgn: first_q, mag: line_bit});
                    sym_valid <= 1'b1;
                    half_q    <= 1'b0;
                end
            end
        end
    end

    a_r5_sym_legal: assert property (@(posedge clk) disable iff (rst)
        sym_valid |-> (sym == LVL_P3 || sym == LVL_P1 || sym == LVL_M1 || sym == LVL_M3));
    a_r4_one_cycle_pulse: assert property (@(posedge clk) disable iff (rst)
        sym_valid |=> !sym_valid);
    a_r4_after_bit: assert property (@(posedge clk) disable iff (rst)
        !bit_valid |=> !sym_valid);
    a_r3_bypass_hold: assert property (@(posedge clk) disable iff (rst)
        (bit_valid && bypass) |=> $stable(hist_q));
    a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !bit_valid |=> ($stable(hist_q) && $stable(half_q)));

endmodule

// File: rtl/qlc_rx.sv
module qlc_rx
    import qlc_pkg::*;
#(
    parameter int DN_A = 5,
    parameter int DN_B = 23,
    parameter int UP_A = 5,
    parameter int UP_B = 23
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       dir_up,
    input  logic       sym_valid,
    input  sym_t       sym,
    input  logic [1:0] bypass,
    output logic       dibit_valid,
    output logic [1:0] dibit
);
    localparam int MAX_DN = (DN_A > DN_B) ? DN_A : DN_B;
    localparam int MAX_UP = (UP_A > UP_B) ? UP_A : UP_B;
    localparam int SR_W   = (MAX_DN > MAX_UP) ? MAX_DN : MAX_UP;

    function automatic logic taps(input logic [SR_W-1:0] s, input logic up);
        return up ? (s[UP_A-1] ^ s[UP_B-1]) : (s[DN_A-1] ^ s[DN_B-1]);
    endfunction

    logic [SR_W-1:0] hist_q;
    logic [SR_W-1:0] mid_st;
    logic [SR_W-1:0] end_st;
    dibit_t          raw;
    logic            b_first;
    logic            b_second;

    always_comb begin
        raw      = sym_to_dibit(sym);
        b_first  = bypass[1] ? raw.sgn : (raw.sgn ^ taps(hist_q, dir_up));
        mid_st   = bypass[1] ? hist_q : {hist_q[SR_W-2:0], raw.sgn};
        b_second = bypass[0] ? raw.mag : (raw.mag ^ taps(mid_st, dir_up));
        end_st   = bypass[0] ? mid_st : {mid_st[SR_W-2:0], raw.mag};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q      <= '0;
            dibit_valid <= 1'b0;
            dibit       <= '0;
        end else begin
            dibit_valid <= sym_valid;
            if (sym_valid) begin
                hist_q <= end_st;
                dibit  <= {b_first, b_second};
            end
        end
    end

    a_r6_latency: assert property (@(posedge clk) disable iff (rst)
        sym_valid |=> dibit_valid);
    a_r6_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !sym_valid |=> !dibit_valid);
    a_r8_full_bypass_hold: assert property (@(posedge clk) disable iff (rst)
        (sym_valid && bypass == 2'b11) |=> $stable(hist_q));
    a_r10_rx_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !sym_valid |=> $stable(hist_q));

endmodule

// File: rtl/quat_line_codec.sv
module quat_line_codec
    import qlc_pkg::*;
#(
    parameter int DN_TAP_A = 5,
    parameter int DN_TAP_B = 23,
    parameter int UP_TAP_A = 5,
    parameter int UP_TAP_B = 23
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       dir_up,
    input  logic       tx_bit_valid,
    input  logic       tx_bit,
    input  logic       tx_bypass,
    output logic       tx_sym_valid,
    output logic [2:0] tx_sym,
    input  logic       rx_sym_valid,
    input  logic [2:0] rx_sym,
    input  logic [1:0] rx_bypass,
    output logic       rx_dibit_valid,
    output logic [1:0] rx_dibit
);
    sym_t tx_sym_s;

    qlc_tx #(.DN_A(DN_TAP_A), .DN_B(DN_TAP_B), .UP_A(UP_TAP_A), .UP_B(UP_TAP_B)) u_tx (
        .clk       (clk),
        .rst       (rst),
        .dir_up    (dir_up),
        .bit_valid (tx_bit_valid),
        .bit_in    (tx_bit),
        .bypass    (tx_bypass),
        .sym_valid (tx_sym_valid),
        .sym       (tx_sym_s)
    );

    assign tx_sym = tx_sym_s;

    qlc_rx #(.DN_A(DN_TAP_A), .DN_B(DN_TAP_B), .UP_A(UP_TAP_A), .UP_B(UP_TAP_B)) u_rx (
        .clk         (clk),
        .rst         (rst),
        .dir_up      (dir_up),
        .sym_valid   (rx_sym_valid),
        .sym         (sym_t'(rx_sym)),
        .bypass      (rx_bypass),
        .dibit_valid (rx_dibit_valid),
        .dibit       (rx_dibit)
    );

    a_r1_reset_quiet: assert property (@(posedge clk)
        $past(rst) |-> (!tx_sym_valid && !rx_dibit_valid));

endmodule

// File: tb/sim_quat_line_codec.sv
module sim_quat_line_codec;

    logic       clk = 1'b0;
    logic       rst;
    logic       dir_up;
    logic       tx_bit_valid, tx_bit, tx_bypass;
    logic       tx_sym_valid;
    logic [2:0] tx_sym;
    logic       rx_sym_valid;
    logic [2:0] rx_sym;
    logic [1:0] rx_bypass;
    logic       rx_dibit_valid;
    logic [1:0] rx_dibit;

    int n_run = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    quat_line_codec u0 (.*);

    // Bench reference state: bit k of each word = line bit sent k+1 bits ago.
    logic [63:0] tx_ref_h;
    logic [63:0] far_h;
    logic [63:0] near_h;
    logic        tx_half;
    logic        tx_first;

    int   exp_sym_q[$];
    int   exp_di_q[$];
    bit   chk_di_q[$];
    string tag_sym_q[$];

    function automatic int level_of(input logic a, input logic b);
        if (a) return b ? 1 : 3;
        return b ? -1 : -3;
    endfunction

    function automatic logic [2:0] enc3(input int v);
        return v[2:0];
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Output monitor, sampling away from the rising edge.
    always @(negedge clk) begin
        if (!rst) begin
            if (tx_sym_valid) begin
                if (exp_sym_q.size() == 0) check(0, "R4 spurious symbol", $signed(tx_sym), 99);
                else begin
                    int e;
                    string t;
                    e = exp_sym_q.pop_front();
                    t = tag_sym_q.pop_front();
                    check(int'($signed(tx_sym)) == e, t, $signed(tx_sym), e);
                end
            end
            if (rx_dibit_valid) begin
                if (exp_di_q.size() == 0) check(0, "R6 spurious pair", rx_dibit, 99);
                else begin
                    int e;
                    bit c;
                    e = exp_di_q.pop_front();
                    c = chk_di_q.pop_front();
                    if (c) check(int'(rx_dibit) == e, "R7/R8/R9 recovered pair", rx_dibit, e);
                end
            end
        end
    end

    task automatic send_tx(input logic b, input logic byp, input logic up, input string tag);
        logic lb;
        @(negedge clk);
        tx_bit_valid = 1'b1; tx_bit = b; tx_bypass = byp; dir_up = up;
        lb = byp ? b : (b ^ tx_ref_h[4] ^ tx_ref_h[22]);     // R2, R3
        if (!byp) tx_ref_h = {tx_ref_h[62:0], lb};
        if (!tx_half) begin
            tx_first = lb; tx_half = 1'b1;
        end else begin
            exp_sym_q.push_back(level_of(tx_first, lb));
            tag_sym_q.push_back(tag);
            tx_half = 1'b0;
        end
        @(negedge clk);
        tx_bit_valid = 1'b0;
    endtask

    // Far-end scrambler feeds the receive port; near_h mirrors the descrambler.
    task automatic send_rx(input logic d1, input logic d2, input logic [1:0] byp, input bit chk);
        logic l1, l2, o1, o2;
        l1 = byp[1] ? d1 : (d1 ^ far_h[4] ^ far_h[22]);
        if (!byp[1]) far_h = {far_h[62:0], l1};
        l2 = byp[0] ? d2 : (d2 ^ far_h[4] ^ far_h[22]);
        if (!byp[0]) far_h = {far_h[62:0], l2};
        o1 = byp[1] ? l1 : (l1 ^ near_h[4] ^ near_h[22]);
        if (!byp[1]) near_h = {near_h[62:0], l1};
        o2 = byp[0] ? l2 : (l2 ^ near_h[4] ^ near_h[22]);
        if (!byp[0]) near_h = {near_h[62:0], l2};
        @(negedge clk);
        rx_sym_valid = 1'b1; rx_sym = enc3(level_of(l1, l2)); rx_bypass = byp;
        exp_di_q.push_back(chk ? int'({d1, d2}) : int'({o1, o2}));
        chk_di_q.push_back(1'b1);
        @(negedge clk);
        rx_sym_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(0, "watchdog", 0, 1);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        rst = 1'b1; dir_up = 0; tx_bit_valid = 0; tx_bit = 0; tx_bypass = 0;
        rx_sym_valid = 0; rx_sym = 0; rx_bypass = 0;
        tx_ref_h = '0; far_h = '0; near_h = '0; tx_half = 0; tx_first = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(!tx_sym_valid, "R1 tx_sym_valid", tx_sym_valid, 0);
        check(!rx_dibit_valid, "R1 rx_dibit_valid", rx_dibit_valid, 0);
        check(tx_sym == 3'b000, "R1 tx_sym", tx_sym, 0);

        // R5: directed bypassed pairs cover all four levels
        send_tx(1, 1, 0, "R5 map 10"); send_tx(0, 1, 0, "R5 map 10");
        send_tx(1, 1, 0, "R5 map 11"); send_tx(1, 1, 0, "R5 map 11");
        send_tx(0, 1, 0, "R5 map 01"); send_tx(1, 1, 0, "R5 map 01");
        send_tx(0, 1, 0, "R5 map 00"); send_tx(0, 1, 0, "R5 map 00");

        // R2: a lone one seeds the history; zeros then echo it at taps 5 and 23
        send_tx(1, 0, 0, "R2 impulse");
        for (int i = 0; i < 59; i++) send_tx(0, 0, 0, "R2 impulse response");

        // R3, R4, R10: random data, bypass mix, idle gaps, direction toggles
        for (int i = 0; i < 600; i++) begin
            int gap;
            send_tx(1'($urandom), ($urandom % 5) == 0, 1'($urandom), "R2/R3/R4/R10 random tx");
            gap = $urandom % 4;
            repeat (gap) @(negedge clk);
        end
        // R4: odd bypassed bit still pairs with the next scrambled bit
        send_tx(1, 1, 0, "R4 mixed pair"); send_tx(0, 0, 0, "R4 mixed pair");
        repeat (4) @(negedge clk);
        check(exp_sym_q.size() == 0, "R4 all symbols seen", exp_sym_q.size(), 0);

        // R6, R7, R8: loopback from aligned zero state
        for (int i = 0; i < 200; i++) begin
            send_rx(1'($urandom), 1'($urandom), 2'($urandom % 4 == 0 ? $urandom : 0), 1'b1);
            repeat ($urandom % 3) @(negedge clk);
        end
        // R8: fully bypassed symbols deliver raw level bits
        send_rx(1, 0, 2'b11, 1'b1); send_rx(0, 1, 2'b11, 1'b1);

        // R9: far end restarts from arbitrary state; resync after 23 bits
        far_h = {$urandom, $urandom};
        for (int i = 0; i < 12; i++) send_rx(1'($urandom), 1'($urandom), 2'b00, 1'b0);
        for (int i = 0; i < 150; i++)
            send_rx(1'($urandom), 1'($urandom), 2'($urandom % 5 == 0 ? $urandom : 0), 1'b1);
        repeat (4) @(negedge clk);
        check(exp_di_q.size() == 0, "R6 all pairs seen", exp_di_q.size(), 0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule